// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block supplies the two lowest word-address bits for a four-beat burst in a synchronous memory front end. A load cycle captures a start value from the two low bits of the presented address, along with the remaining upper bits. Each later advance cycle steps to the next beat of the burst.

The beat order is picked by a static order-select input. In linear order the start value counts up by one modulo four. In interleaved order the start value is XORed with the beat index. A hold input freezes the whole block as if the clock edge had not occurred. A load cycle that arrives while the device is not selected ends any burst in progress.

The low address output is formed from the registered start value, the registered beat index and the order-select input. Because that input is treated as static, it reaches the output without a register.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `lo_addr` is 0, `hi_addr` is 0 and `burst_on` is 0.
- R2: At an edge with `hold`=0, `adv_nload`=0 and `sel`=1, the block loads. After that edge, `lo_addr` equals the sampled `seed_lo`, `hi_addr` equals the sampled `addr_hi`, and `burst_on` is 1.
- R3: With `order_ilv`=0 (linear), the k-th advance after a load (`hold`=0, `adv_nload`=1) gives `lo_addr` = (seed + k) mod 4. For example, seed 1 gives 1,2,3,0.
- R4: With `order_ilv`=1 (interleaved), `lo_addr` = seed XOR (k mod 4). For example, seed 1 gives 1,0,3,2.
- R5: After the fourth beat, further advances repeat the same four-value sequence, and `burst_on` stays 1.
- R6: `hi_addr` does not change on advance cycles. It only changes on a selected load.
- R7: At an edge with `hold`=1, the registered state does not change, whatever the other inputs are. `lo_addr`, `hi_addr` and `burst_on` are unchanged when `order_ilv` is held.
- R8: A load cycle with `sel`=0 clears `burst_on` and leaves `lo_addr` and `hi_addr` unchanged.
- R9: An advance cycle while `burst_on`=0 leaves `lo_addr` and `hi_addr` unchanged and `burst_on` at 0.
- R10: A selected load during an active burst restarts the sequence from the new seed at beat 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold | input | 1 | 1 freezes all state at this edge |
| adv_nload | input | 1 | 0 = load cycle, 1 = advance cycle |
| sel | input | 1 | Device selected, qualifies a load |
| seed_lo | input | 2 | Low address bits captured as the burst start |
| addr_hi | input | HI_W | Upper address bits captured on load |
| order_ilv | input | 1 | Static order select: 1 interleaved, 0 linear |
| lo_addr | output | 2 | Current low word address of the burst |
| hi_addr | output | HI_W | Upper address held from the last load |
| burst_on | output | 1 | A burst is active |

## Verification
Every registered result becomes visible on the first rising edge after the inputs are sampled:
- a load shows the new seed, upper bits and active flag after that edge;
- an advance shows the next beat after that edge;
- a hold or a deselect shows its effect, frozen or cleared, after that same edge.

The bench drives inputs at the falling edge and updates its reference model right after the rising edge. It compares 2 ns later, so each result is checked in the cycle it is due. The order select acts without a register, but the bench only changes it together with the other inputs, so the same sample point covers it.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int unsigned BEAT_W = 2;

    typedef enum logic [2:0] {
        OP_FREEZE = 3'd0,
        OP_LOAD   = 3'd1,
        OP_DESEL  = 3'd2,
        OP_STEP   = 3'd3,
        OP_IDLE   = 3'd4
    } burst_op_e;

    function automatic burst_op_e decode_op(input logic hold,
                                            input logic adv_nload,
                                            input logic sel,
                                            input logic active);
        burst_op_e op;
        if (hold)            op = OP_FREEZE;
        else if (!adv_nload) op = sel ? OP_LOAD : OP_DESEL;
        else                 op = active ? OP_STEP : OP_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/burst_next_state.sv
module burst_next_state
    import burst_pkg::*;
#(
    parameter int unsigned HI_W = 16
) (
    input  logic              hold,
    input  logic              adv_nload,
    input  logic              sel,
    input  logic [BEAT_W-1:0] seed_in,
    input  logic [HI_W-1:0]   hi_in,
    input  logic [BEAT_W-1:0] seed_q,
    input  logic [BEAT_W-1:0] beat_q,
    input  logic [HI_W-1:0]   hi_q,
    input  logic              on_q,
    output logic [BEAT_W-1:0] seed_d,
    output logic [BEAT_W-1:0] beat_d,
    output logic [HI_W-1:0]   hi_d,
    output logic              on_d
);

    burst_op_e op;

    always_comb begin
        op     = decode_op(hold, adv_nload, sel, on_q);
        seed_d = seed_q;
        beat_d = beat_q;
        hi_d   = hi_q;
        on_d   = on_q;
        unique case (op)
            OP_LOAD: begin
                seed_d = seed_in;
                beat_d = '0;
                hi_d   = hi_in;
                on_d   = 1'b1;
            end
            OP_DESEL: on_d = 1'b0;
            OP_STEP:  beat_d = beat_q + BEAT_W'(1);
            default: ;
        endcase
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  logic              order_ilv,
    input  logic [BEAT_W-1:0] seed,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] addr
);

    logic [BEAT_W-1:0] lin_addr;
    logic [BEAT_W-1:0] ilv_addr;
    logic [BEAT_W:0]   carry;

    assign carry[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < BEAT_W; g++) begin : g_bit
            assign lin_addr[g]  = seed[g] ^ beat[g] ^ carry[g];
            assign carry[g+1]   = (seed[g] & beat[g]) | (carry[g] & (seed[g] ^ beat[g]));
            assign ilv_addr[g]  = seed[g] ^ beat[g];
        end
    endgenerate

    assign addr = order_ilv ? ilv_addr : lin_addr;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int unsigned HI_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              adv_nload,
    input  logic              sel,
    input  logic [1:0]        seed_lo,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic              order_ilv,
    output logic [1:0]        lo_addr,
    output logic [HI_W-1:0]   hi_addr,
    output logic              burst_on
);

    typedef struct packed {
        logic [BEAT_W-1:0] seed;
        logic [BEAT_W-1:0] beat;
        logic [HI_W-1:0]   hi;
        logic              on;
    } burst_state_t;

    burst_state_t st_d, st_q;

    burst_next_state #(.HI_W(HI_W)) i_next (
        .hold      (hold),
        .adv_nload (adv_nload),
        .sel       (sel),
        .seed_in   (seed_lo),
        .hi_in     (addr_hi),
        .seed_q    (st_q.seed),
        .beat_q    (st_q.beat),
        .hi_q      (st_q.hi),
        .on_q      (st_q.on),
        .seed_d    (st_d.seed),
        .beat_d    (st_d.beat),
        .hi_d      (st_d.hi),
        .on_d      (st_d.on)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    burst_order_map i_map (
        .order_ilv (order_ilv),
        .seed      (st_q.seed),
        .beat      (st_q.beat),
        .addr      (lo_addr)
    );

    assign hi_addr  = st_q.hi;
    assign burst_on = st_q.on;

    // R2: a selected load captures the upper bits and raises the flag
    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !adv_nload && sel) |=> (st_q.on && st_q.hi == $past(addr_hi)
                                          && st_q.beat == '0 && st_q.seed == $past(seed_lo)));

    // R3: an advance inside a burst moves the beat index by one (mod 4)
    p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && adv_nload && st_q.on) |=> (st_q.beat == $past(st_q.beat) + BEAT_W'(1)
                                             && $stable(st_q.seed) && st_q.on));

    // R6: upper bits never move on an advance cycle
    p_hi_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_nload) |=> $stable(st_q.hi));

    // R7: hold freezes every piece of state
    p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(st_q.seed) && $stable(st_q.beat) && $stable(st_q.hi) && $stable(st_q.on)));

    // R8: a deselected load ends the burst without moving the address
    p_desel_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !adv_nload && !sel) |=> (!st_q.on && $stable(st_q.hi) && $stable(st_q.beat)));

    // R9: advance with no burst leaves everything alone
    p_idle_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && adv_nload && !st_q.on) |=> (!st_q.on && $stable(st_q.beat) && $stable(st_q.seed)));

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

    localparam int unsigned HI_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hold = 1'b0;
    logic            adv_nload = 1'b1;
    logic            sel = 1'b0;
    logic [1:0]      seed_lo = '0;
    logic [HI_W-1:0] addr_hi = '0;
    logic            order_ilv = 1'b0;
    logic [1:0]      lo_addr;
    logic [HI_W-1:0] hi_addr;
    logic            burst_on;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [1:0]      m_seed = '0;
    logic [1:0]      m_beat = '0;
    logic [HI_W-1:0] m_hi = '0;
    logic            m_on = 1'b0;

    always #4 clk = ~clk;

    burst_addr_gen #(.HI_W(HI_W)) i_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .hold(hold), .adv_nload(adv_nload), .sel(sel),
        .seed_lo(seed_lo), .addr_hi(addr_hi), .order_ilv(order_ilv),
        .lo_addr(lo_addr), .hi_addr(hi_addr), .burst_on(burst_on)
    );

    function automatic logic [1:0] exp_lo(input logic [1:0] s, input logic [1:0] b, input logic ilv);
        return ilv ? (s ^ b) : 2'(s + b);
    endfunction

    task automatic check(input string tag);
        logic [1:0] e_lo;
        e_lo = exp_lo(m_seed, m_beat, order_ilv);
        n_cmp++;
        if (lo_addr !== e_lo || hi_addr !== m_hi || burst_on !== m_on) begin
            n_bad++;
            $display("FAIL %s: lo=%0d hi=%h on=%0b expected lo=%0d hi=%h on=%0b",
                     tag, lo_addr, hi_addr, burst_on, e_lo, m_hi, m_on);
        end
    endtask

    task automatic step(input logic h, input logic a, input logic s, input logic [1:0] sd,
                        input logic [HI_W-1:0] ah, input logic ilv, input string tag);
        @(negedge clk);
        hold = h; adv_nload = a; sel = s; seed_lo = sd; addr_hi = ah; order_ilv = ilv;
        @(posedge clk);
        if (!h) begin
            if (!a) begin
                if (s) begin m_seed = sd; m_beat = 2'd0; m_hi = ah; m_on = 1'b1; end
                else m_on = 1'b0;
            end else if (m_on) begin
                m_beat = m_beat + 2'd1;
            end
        end
        #2;
        check(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R9: advance with no burst active
        step(0, 1, 1, 2'd3, 16'h1111, 0, "R9 idle advance");
        // R2 load then R3 linear walk with R5 wrap and R6 steady upper bits
        step(0, 0, 1, 2'd1, 16'hA5A5, 0, "R2 load");
        for (int k = 0; k < 6; k++)
            step(0, 1, 0, 2'd2, 16'hFFFF, 0, "R3 R5 R6 linear advance");
        // R4 interleaved walk from seed 1 and seed 2
        step(0, 0, 1, 2'd1, 16'h0F0F, 1, "R2 load ilv");
        for (int k = 0; k < 5; k++)
            step(0, 1, 1, 2'd0, 16'h0000, 1, "R4 R5 interleaved advance");
        step(0, 0, 1, 2'd2, 16'h3C3C, 1, "R10 reload mid-burst");
        step(0, 1, 1, 2'd0, 16'h0000, 1, "R4 interleaved seed2");
        // R7 hold with a load presented
        step(1, 0, 1, 2'd3, 16'hDEAD, 1, "R7 hold ignores load");
        step(1, 1, 0, 2'd0, 16'hBEEF, 1, "R7 hold ignores advance");
        // R8 deselect then R9 idle advance
        step(0, 0, 0, 2'd3, 16'h7777, 1, "R8 deselect");
        step(0, 1, 1, 2'd1, 16'h8888, 1, "R9 advance after deselect");
        step(0, 0, 1, 2'd3, 16'h1234, 0, "R2 load seed3");
        step(0, 1, 0, 2'd0, 16'h0000, 0, "R3 linear wrap 3->0");
        step(0, 0, 1, 2'd0, 16'h4321, 0, "R10 reload linear");

        for (int i = 0; i < 3000; i++) begin
            logic h, a, s, ilv;
            h   = ($urandom % 8) == 0;
            a   = ($urandom % 4) != 0;
            s   = ($urandom % 5) != 0;
            ilv = (i / 500) % 2 == 1;
            step(h, a, s, 2'($urandom), HI_W'($urandom), ilv,
                 h ? "R7 random" : (!a ? (s ? "R2 R10 random" : "R8 random")
                                       : (m_on ? "R3 R4 R6 random" : "R9 random")));
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : seed_rng
        int unsigned dummy;
        dummy = $urandom(32'd20240917);
    end

endmodule